// File: doc/BRIEF.md
# Register Configuration Table Engine

This block applies a table of register updates to a memory-mapped register bus. The table arrives as a stream of 32-bit words on a valid/ready input. Three consecutive words form one entry: a target register address, a mask of bits to force to one, and a mask of bits to force to zero. For each entry the engine reads the target register, merges the two masks into the value it read, and writes the result back. It then takes the next entry.

A pulse on `start` arms the engine. It also clears the finished flag, the error flag and the count of applied entries. The walk ends when an entry made entirely of zero words arrives. At that point the engine raises `done` and holds it until the next `start`. An entry whose address is not aligned to the bus word is not applied. It causes no bus access and sets a sticky error flag. The engine then goes on with the next entry.

The bus uses a single request line with a separate write-enable. The request and its address, direction and data stay in place until the acknowledge. A boot or power-up sequencer would use the block to apply a fixed list of register fixups, supplied by a ROM, a serial loader or a host, without using a processor.

Top module: `regcfg_engine`

## Requirements
- R1: An entry is three words accepted on `in_valid && in_ready` in the order address, set mask, clear mask. Words offered while `in_ready` is low are not taken.
- R2: For an applied entry, the engine first requests a read (`bus_we`=0) of the entry address. Only after that read is acknowledged does it request a write (`bus_we`=1) to the same address. The write data is `(old & ~clear) | set`, where `old` is `bus_rdata` at the read acknowledge. A bit present in both masks ends up at one.
- R3: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold their values into the next cycle.
- R4: `in_ready` is high only while words are being collected. It is never high together with `bus_req`. The first word of the next entry is not accepted before the write of the current entry is acknowledged.
- R5: An entry whose three words are all zero ends the table. It causes no bus access. `done` is high from the cycle after its last word is accepted and stays high until a new `start`. An entry with any non-zero word is not a terminator, including one with address zero.
- R6: An entry whose address has either of its two low bits non-zero causes no bus access and sets `error`. `error` stays set until the next `start`. Word collection resumes with the next entry.
- R7: `applied_cnt` increments by one on each write acknowledge and clears on an accepted `start`. Skipped entries and terminators do not change it.
- R8: `start` is honoured only when the engine is idle or done. A `start` during a walk is ignored and clears nothing.
- R9: After reset, `in_ready`, `bus_req`, `done` and `error` are low and `applied_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new table walk |
| in_valid | input | 1 | Table word available |
| in_data | input | 32 | Table word |
| in_ready | output | 1 | Engine takes a word this cycle when valid |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled at acknowledge |
| bus_ack | input | 1 | Bus acknowledge |
| done | output | 1 | Terminator seen, walk finished |
| error | output | 1 | A misaligned entry was skipped |
| applied_cnt | output | 8 | Entries applied since start |

## Verification
A wrong internal phase shows up at once at the ports. `in_ready` and `bus_req` both follow the phase, so a wrong phase either asserts the wrong one or drops both in the same cycle. The reference model tracks every handshake and compares both lines on every clock. A wrong merge, or a stale captured read value, shows up on `bus_wdata` in the first cycle of the write request, long before the register value is checked. A word stored in the wrong slot shows up either as a request to a wrong address or as a wrong terminator or skip decision. That decision becomes visible one cycle after the third word, on `done`, `error` or `bus_req`.

// File: rtl/regcfg_pkg.sv
package regcfg_pkg;
  typedef enum logic [2:0] {
    RC_IDLE,
    RC_ADDR,
    RC_SETM,
    RC_CLRM,
    RC_READ,
    RC_WRITE,
    RC_FIN
  } rc_state_e;
endpackage

// File: rtl/regcfg_seq.sv
module regcfg_seq
  import regcfg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          bus_ack,
  output rc_state_e     state,
  output logic          in_ready,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] set_q,
  output logic [DW-1:0] clr_q,
  output logic          rd_take,
  output logic          wr_take,
  output logic          start_ok,
  output logic          done,
  output logic          error
);
  localparam int LSB = $clog2(DW / 8);

  rc_state_e state_q, state_d;
  logic      accept, last_word, term, misal;
  logic      addr_en, set_en, clr_en;
  logic      done_q, done_d, err_q, err_d;

  assign in_ready  = (state_q == RC_ADDR) || (state_q == RC_SETM) || (state_q == RC_CLRM);
  assign accept    = in_valid && in_ready;
  assign last_word = accept && (state_q == RC_CLRM);
  assign term      = (addr_q == '0) && (set_q == '0) && (in_data == '0);
  assign misal     = |addr_q[LSB-1:0];
  assign start_ok  = start && ((state_q == RC_IDLE) || (state_q == RC_FIN));
  assign rd_take   = (state_q == RC_READ) && bus_ack;
  assign wr_take   = (state_q == RC_WRITE) && bus_ack;

  assign addr_en = accept && (state_q == RC_ADDR);
  assign set_en  = accept && (state_q == RC_SETM);
  assign clr_en  = last_word;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RC_IDLE, RC_FIN: if (start_ok) state_d = RC_ADDR;
      RC_ADDR:         if (accept) state_d = RC_SETM;
      RC_SETM:         if (accept) state_d = RC_CLRM;
      RC_CLRM: begin
        if (accept) begin
          if (term)       state_d = RC_FIN;
          else if (misal) state_d = RC_ADDR;
          else            state_d = RC_READ;
        end
      end
      RC_READ:         if (bus_ack) state_d = RC_WRITE;
      RC_WRITE:        if (bus_ack) state_d = RC_ADDR;
      default:         state_d = RC_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    if (start_ok) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end else if (last_word) begin
      if (term)       done_d = 1'b1;
      else if (misal) err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RC_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      set_q  <= '0;
      clr_q  <= '0;
    end else begin
      if (addr_en) addr_q <= in_data;
      if (set_en)  set_q  <= in_data;
      if (clr_en)  clr_q  <= in_data;
    end
  end

  assign state = state_q;
  assign done  = done_q;
  assign error = err_q;
endmodule

// File: rtl/regcfg_merge.sv
module regcfg_merge #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] set_m,
  input  logic [DW-1:0] clr_m,
  output logic [DW-1:0] wdata
);
  logic [DW-1:0] old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (cap_en) old_q <= rdata;
  end

  assign wdata = (old_q & ~clr_m) | set_m;
endmodule

// File: rtl/regcfg_tally.sv
module regcfg_tally #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/regcfg_engine.sv
module regcfg_engine
  import regcfg_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] applied_cnt
);
  rc_state_e     state;
  logic [DW-1:0] addr_q, set_q, clr_q;
  logic          rd_take, wr_take, start_ok;

  regcfg_seq #(.DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_data  (in_data),
    .bus_ack  (bus_ack),
    .state    (state),
    .in_ready (in_ready),
    .addr_q   (addr_q),
    .set_q    (set_q),
    .clr_q    (clr_q),
    .rd_take  (rd_take),
    .wr_take  (wr_take),
    .start_ok (start_ok),
    .done     (done),
    .error    (error)
  );

  regcfg_merge #(.DW(DW)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (rd_take),
    .rdata  (bus_rdata),
    .set_m  (set_q),
    .clr_m  (clr_q),
    .wdata  (bus_wdata)
  );

  regcfg_tally #(.CW(CW)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .inc   (wr_take),
    .cnt   (applied_cnt)
  );

  assign bus_req  = (state == RC_READ) || (state == RC_WRITE);
  assign bus_we   = (state == RC_WRITE);
  assign bus_addr = addr_q;
endmodule

// File: rtl/regcfg_engine_chk.sv
module regcfg_engine_chk #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_ack,
  input logic [DW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          done,
  input logic [CW-1:0] applied_cnt
);
  localparam int            LSB   = $clog2(DW / 8);
  localparam logic [DW-1:0] AMASK = DW'((1 << LSB) - 1);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !bus_req);

  p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && !$past(bus_we) |-> $past(bus_req && bus_ack));

  p_aligned_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr & AMASK) == '0);

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !bus_req);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    applied_cnt != $past(applied_cnt) |->
      (applied_cnt == CW'($past(applied_cnt) + 1'b1) && $past(bus_req && bus_we && bus_ack))
      || applied_cnt == '0);
endmodule

bind regcfg_engine regcfg_engine_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_ack     (bus_ack),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .done        (done),
  .applied_cnt (applied_cnt)
);

// File: tb/sim_regcfg_engine.sv
module sim_regcfg_engine;
  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n, start, in_valid, bus_ack;
  logic [DW-1:0] in_data, bus_rdata;
  logic          in_ready, bus_req, bus_we, done, error;
  logic [DW-1:0] bus_addr, bus_wdata;
  logic [CW-1:0] applied_cnt;

  always #10 clk = ~clk;

  regcfg_engine #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .done(done), .error(error), .applied_cnt(applied_cnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit running = 0;
  bit go_start = 0;
  logic [31:0] feed[$];
  logic [31:0] mem[logic [31:0]];
  logic [31:0] exp_mem[logic [31:0]];

  // reference model: 0 idle, 1 collecting, 2 reading, 3 writing, 4 finished
  int ph = 0;
  int wi = 0;
  logic [31:0] ea, es, ec, old;
  int  cnt = 0;
  bit  err = 0;

  logic        s_start, s_valid, s_ready, s_req, s_we, s_ack;
  logic [31:0] s_data, s_addr, s_rdata, s_wdata;

  function automatic logic [31:0] seed_val(logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] bus_view(logic [31:0] a);
    return mem.exists(a) ? mem[a] : seed_val(a);
  endfunction

  function automatic logic [31:0] ref_view(logic [31:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : seed_val(a);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        finish_run();
      end
      // model update from the values present across the last rising edge
      if (s_start && (ph == 0 || ph == 4)) begin
        ph = 1; wi = 0; cnt = 0; err = 0;
      end else begin
        case (ph)
          1: if (s_valid && s_ready) begin
               void'(feed.pop_front());
               if (wi == 0)      ea = s_data;
               else if (wi == 1) es = s_data;
               else              ec = s_data;
               if (wi < 2) wi++;
               else begin
                 wi = 0;
                 if (ea == 0 && es == 0 && ec == 0) ph = 4;
                 else if (ea[1:0] != 2'b00)          err = 1;
                 else                                ph = 2;
               end
             end
          2: if (s_req && s_ack) begin old = s_rdata; ph = 3; end
          3: if (s_req && s_ack) begin
               mem[s_addr] = s_wdata;
               exp_mem[ea] = (ref_view(ea) & ~ec) | es;
               cnt++;
               ph = 1;
             end
          default: ;
        endcase
      end
      // compare every clock
      chk("R4", "in_ready", {31'b0, in_ready}, {31'b0, ph == 1});
      chk("R2", "bus_req", {31'b0, bus_req}, {31'b0, ph == 2 || ph == 3});
      if (ph == 2 || ph == 3) begin
        chk("R2", "bus_addr", bus_addr, ea);
        chk("R2", "bus_we", {31'b0, bus_we}, {31'b0, ph == 3});
      end
      if (ph == 3) chk("R3", "bus_wdata", bus_wdata, (old & ~ec) | es);
      chk("R5", "done", {31'b0, done}, {31'b0, ph == 4});
      chk("R6", "error", {31'b0, error}, {31'b0, err});
      chk("R7", "applied_cnt", {24'b0, applied_cnt}, cnt[31:0] & 32'hFF);
      // drive next inputs
      start    = go_start;
      go_start = 0;
      begin
        bit hold;
        hold = in_valid && !in_ready;
        in_valid = (feed.size() > 0) && (hold || ($urandom % 4 != 0));
        in_data  = in_valid ? feed[0] : $urandom;
      end
      bus_ack   = bus_req && ($urandom % 3 == 0);
      bus_rdata = bus_req ? bus_view(bus_addr) : $urandom;
      // snapshot for the next edge
      s_start = start;   s_valid = in_valid; s_data  = in_data;
      s_ready = in_ready; s_req  = bus_req;  s_we    = bus_we;
      s_ack   = bus_ack; s_addr  = bus_addr; s_rdata = bus_rdata;
      s_wdata = bus_wdata;
    end
  end

  task automatic push_entry(logic [31:0] a, logic [31:0] s, logic [31:0] c);
    feed.push_back(a);
    feed.push_back(s);
    feed.push_back(c);
  endtask

  task automatic run_table();
    go_start = 1;
    repeat (4) @(posedge clk);
    while (!(ph == 4 && feed.size() == 0)) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    rst_n = 0; start = 0; in_valid = 0; in_data = '0; bus_ack = 0; bus_rdata = '0;
    s_start = 0; s_valid = 0; s_ready = 0; s_req = 0; s_we = 0; s_ack = 0;
    s_data = '0; s_addr = '0; s_rdata = '0; s_wdata = '0;
    ea = '0; es = '0; ec = '0; old = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "in_ready", {31'b0, in_ready}, 32'd0);
    chk("R9", "bus_req", {31'b0, bus_req}, 32'd0);
    chk("R9", "done", {31'b0, done}, 32'd0);
    chk("R9", "error", {31'b0, error}, 32'd0);
    chk("R9", "applied_cnt", {24'b0, applied_cnt}, 32'd0);
    rst_n = 1;
    running = 1;
    repeat (4) @(posedge clk);

    // Table 1: masks, overlap, misaligned skip, address zero, revisit (R1 R2 R6)
    push_entry(32'h0000_0100, 32'h0000_00FF, 32'hFFFF_0000);
    push_entry(32'h0000_0104, 32'h0F0F_0000, 32'h0F0F_0000);
    push_entry(32'h0000_0102, 32'h0000_0001, 32'h0000_0001);
    push_entry(32'h0000_0000, 32'h8000_0000, 32'h0000_0000);
    push_entry(32'h0000_0100, 32'h0000_0100, 32'h0000_0001);
    push_entry(32'h0, 32'h0, 32'h0);
    go_start = 1;
    repeat (4) @(posedge clk);
    while (cnt < 1) @(posedge clk);
    go_start = 1;  // R8: start during the walk must be ignored
    repeat (4) @(posedge clk);
    while (!(ph == 4 && feed.size() == 0)) @(posedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R8", "applied_cnt after ignored start", {24'b0, applied_cnt}, 32'd4);
    chk("R6", "sticky error", {31'b0, error}, 32'd1);
    chk("R5", "done held", {31'b0, done}, 32'd1);
    chk("R2", "overlap bits set", bus_view(32'h104) & 32'h0F0F_0000, 32'h0F0F_0000);

    // Table 2: only a misaligned entry then terminator (R6)
    push_entry(32'h0000_01FF, 32'h1, 32'h0);
    push_entry(32'h0, 32'h0, 32'h0);
    run_table();
    @(negedge clk);
    chk("R6", "error after skip", {31'b0, error}, 32'd1);
    chk("R7", "no count on skip", {24'b0, applied_cnt}, 32'd0);

    // Table 3: immediate terminator clears error (R5 R6)
    push_entry(32'h0, 32'h0, 32'h0);
    run_table();
    @(negedge clk);
    chk("R6", "error cleared by start", {31'b0, error}, 32'd0);
    chk("R5", "done on bare terminator", {31'b0, done}, 32'd1);

    // Table 4: zero address and set, non-zero clear is not a terminator (R5)
    push_entry(32'h0, 32'h0, 32'h0000_0010);
    push_entry(32'h0000_0200, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    push_entry(32'h0, 32'h0, 32'h0);
    run_table();
    @(negedge clk);
    chk("R5", "partial-zero entry applied", {24'b0, applied_cnt}, 32'd2);
    chk("R2", "all-ones set wins", bus_view(32'h200), 32'hFFFF_FFFF);

    // final register image and no access to skipped addresses (R2 R6)
    foreach (exp_mem[k]) chk("R2", $sformatf("reg %h", k), bus_view(k), exp_mem[k]);
    chk("R6", "registers touched", mem.num(), exp_mem.num());
    chk("R6", "misaligned never written", {31'b0, mem.exists(32'h102) || mem.exists(32'h1FF)}, 32'd0);
    finish_run();
  end
endmodule